// File: doc/BRIEF.md
# Field-Synchronised Overlay Toggle Controller

This block lets an operator switch two overlay layers of a video mixer on and off with two push-buttons, for example a clock graphic or a caption. A press never changes the picture at once. It opens a pending request for its channel. The request first waits for a falling edge of horizontal sync. After that edge it counts falling edges of the field-blanking signal, and the overlay enable flips only when the count reaches the configured number, six by default. The switch therefore falls inside blanking and leaves the visible background picture undisturbed.

Each channel drives an overlay-enable line to the mixer and an indicator LED. The two channels are independent, so both overlays may be shown together. A one-cycle request input per channel lets a remote command path start the same deferred toggle without a button.

Top module: `overlay_toggle_ctrl`

## Requirements
- R1: Reset (rst_n low) forces both overlay enables and both LEDs to 0 and drops any pending request, so edges seen after reset change nothing until a new press arrives.
- R2: Buttons are active high. A press is accepted only once the synchronised button level has stayed high for DEBOUNCE_CYCLES clocks. A shorter pulse causes no toggle.
- R3: Each accepted press inverts the overlay enable of its own channel (bit 0 = channel 0, bit 1 = channel 1). The channels do not affect each other, and both may be on together.
- R4: After a press, field-blanking falling edges seen before the next horizontal-sync falling edge are not counted.
- R5: The enable changes on the FIELD_EDGES-th (default 6) field-blanking falling edge after that horizontal-sync falling edge, and on no earlier edge.
- R6: Each LED output equals its overlay enable in every clock cycle.
- R7: A press or request arriving while the same channel already has a toggle pending is ignored, so one press gives exactly one state change.
- R8: A one-cycle high pulse on req_i[n] starts the same deferred toggle as an accepted press on button n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_i | input | CHANNELS | Raw push-button levels, active high |
| hsync_i | input | 1 | Horizontal sync, asynchronous to clk |
| fblank_i | input | 1 | Field blanking, asynchronous to clk |
| req_i | input | CHANNELS | Synchronous one-cycle toggle requests |
| ovl_en_o | output | CHANNELS | Overlay enable per channel |
| led_o | output | CHANNELS | Indicator LED per channel |

## Verification
The bench applies a glitch shorter than the debounce window, which a design without a working debouncer would turn into a toggle. It sends field-blanking edges before any horizontal-sync edge, which a design that skips the sync wait would count. It checks the enable after the fifth edge as well as the sixth, which catches an off-by-one edge counter. A second press inside a pending window and a reset in the middle of a count expose a design that toggles twice or keeps a stale request.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_WAIT_HS = 2'd1,
    SEQ_COUNT   = 2'd2
  } seq_state_t;

  // clock cycles for a debounce window given in milliseconds
  function automatic int unsigned db_cycles(input int unsigned clk_hz, input int unsigned ms);
    return (clk_hz / 1000) * ms;
  endfunction

  // bits needed to count 0..n-1, never fewer than one
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/ovl_sync.sv
module ovl_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/ovl_debounce.sv
module ovl_debounce #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic press_o
);
  localparam int unsigned CW  = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;
  logic          press_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      lvl_q   <= 1'b0;
      press_q <= 1'b0;
    end else begin
      press_q <= 1'b0;
      if (raw_i == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LIM) begin
        cnt_q   <= '0;
        lvl_q   <= raw_i;
        press_q <= raw_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign press_o = press_q;

  AST_DB_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM) else $error("debounce counter out of range"); // R2
  AST_DB_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    press_o |=> !press_o) else $error("press pulse longer than one cycle"); // R2
  AST_DB_PRESS_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    press_o |-> $past(raw_i)) else $error("press without high input"); // R2
endmodule

// File: rtl/ovl_chan_seq.sv
module ovl_chan_seq #(
  parameter int unsigned FIELD_EDGES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic hs_fall_i,
  input  logic fb_fall_i,
  output logic en_o,
  output logic busy_o
);
  import ovl_pkg::*;

  localparam int unsigned CW = cnt_width(FIELD_EDGES);
  localparam logic [CW-1:0] LAST = CW'(FIELD_EDGES - 1);

  seq_state_t    state_q;
  logic [CW-1:0] cnt_q;
  logic          en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      en_q    <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_i) state_q <= SEQ_WAIT_HS;
        end
        SEQ_WAIT_HS: begin
          if (hs_fall_i) begin
            state_q <= SEQ_COUNT;
            cnt_q   <= '0;
          end
        end
        SEQ_COUNT: begin
          if (fb_fall_i) begin
            if (cnt_q == LAST) begin
              en_q    <= ~en_q;
              cnt_q   <= '0;
              state_q <= SEQ_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign en_o   = en_q;
  assign busy_o = (state_q != SEQ_IDLE);

  AST_EN_ON_FB_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q != $past(en_q)) |-> $past(fb_fall_i)) else $error("enable moved without field edge"); // R5
  AST_COUNT_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_COUNT && $past(state_q) == SEQ_WAIT_HS) |-> $past(hs_fall_i)) else $error("count began without hsync edge"); // R4
  AST_BUSY_PRESS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_COUNT && start_i && !fb_fall_i) |=> (state_q == SEQ_COUNT && $stable(cnt_q))) else $error("press disturbed pending toggle"); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST) else $error("edge counter overflow"); // R5
endmodule

// File: rtl/overlay_toggle_ctrl.sv
module overlay_toggle_ctrl #(
  parameter int unsigned CHANNELS        = 2,
  parameter int unsigned DEBOUNCE_CYCLES = ovl_pkg::db_cycles(27_000_000, 20),
  parameter int unsigned FIELD_EDGES     = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] btn_i,
  input  logic                hsync_i,
  input  logic                fblank_i,
  input  logic [CHANNELS-1:0] req_i,
  output logic [CHANNELS-1:0] ovl_en_o,
  output logic [CHANNELS-1:0] led_o
);
  localparam int unsigned SW = CHANNELS + 2;

  logic [SW-1:0]       sync_s;
  logic [CHANNELS-1:0] btn_s;
  logic                hs_s, fb_s, hs_prev_q, fb_prev_q;
  logic                hs_fall, fb_fall;
  logic [CHANNELS-1:0] press, start, busy, en;

  ovl_sync #(.W(SW)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({btn_i, hsync_i, fblank_i}),
    .q_o   (sync_s)
  );

  assign btn_s = sync_s[SW-1:2];
  assign hs_s  = sync_s[1];
  assign fb_s  = sync_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_prev_q <= 1'b0;
      fb_prev_q <= 1'b0;
    end else begin
      hs_prev_q <= hs_s;
      fb_prev_q <= fb_s;
    end
  end

  assign hs_fall = hs_prev_q & ~hs_s;
  assign fb_fall = fb_prev_q & ~fb_s;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    ovl_debounce #(.CYCLES(DEBOUNCE_CYCLES)) u_db (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (btn_s[c]),
      .press_o (press[c])
    );

    assign start[c] = press[c] | req_i[c];

    ovl_chan_seq #(.FIELD_EDGES(FIELD_EDGES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start[c]),
      .hs_fall_i (hs_fall),
      .fb_fall_i (fb_fall),
      .en_o      (en[c]),
      .busy_o    (busy[c])
    );

    AST_IDLE_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy[c] && !start[c]) |=> $stable(en[c])) else $error("idle channel changed enable"); // R3
  end

  assign ovl_en_o = en;
  assign led_o    = en;

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    hs_fall |=> !hs_fall) else $error("hsync fall held two cycles"); // R4
endmodule

// File: tb/tb_overlay_toggle_ctrl.sv
module tb_overlay_toggle_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 2;
  localparam int DB = 8;
  localparam int FE = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CH-1:0] btn = '0, req = '0;
  logic          hsync = 1'b0, fblank = 1'b0;
  logic [CH-1:0] en, led;
  logic [CH-1:0] model;
  int checks = 0, errors = 0;

  // mask in [3:2], expected enables after the toggle in [1:0]
  localparam logic [3:0] VEC [0:5] = '{4'b0101, 4'b1011, 4'b0110, 4'b1101, 4'b1110, 4'b1000};

  overlay_toggle_ctrl #(.CHANNELS(CH), .DEBOUNCE_CYCLES(DB), .FIELD_EDGES(FE)) dut (
    .clk(clk), .rst_n(rst_n), .btn_i(btn), .hsync_i(hsync), .fblank_i(fblank),
    .req_i(req), .ovl_en_o(en), .led_o(led)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [CH-1:0] got, input logic [CH-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic press_btn(input logic [CH-1:0] m);
    btn = m; tick(20); btn = '0; tick(20);
  endtask

  task automatic hs_edge();
    hsync = 1'b1; tick(4); hsync = 1'b0; tick(6);
  endtask

  task automatic fb_edges(input int n);
    for (int i = 0; i < n; i++) begin
      fblank = 1'b1; tick(4); fblank = 1'b0; tick(6);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog got timeout expected completion");
        finish_run();
      end
    end
  end

  initial begin
    tick(4);
    check("R1 reset enable", en, 2'b00);
    check("R1 reset led", led, 2'b00);
    rst_n = 1'b1;
    tick(4);
    model = '0;

    // table walk: R3 toggle per channel, R5 sixth edge, R6 led follows
    for (int v = 0; v < 6; v++) begin
      press_btn(VEC[v][3:2]);
      hs_edge();
      fb_edges(FE - 1);
      check("R5 no change before last edge", en, model);
      fb_edges(1);
      model = VEC[v][1:0];
      check("R3 toggled enables", en, model);
      check("R6 led equals enable", led, en);
    end

    // R2: glitch shorter than debounce window is dropped
    btn = 2'b01; tick(3); btn = '0; tick(20);
    hs_edge(); fb_edges(FE);
    check("R2 short glitch ignored", en, 2'b00);

    // R4: field edges before hsync are not counted
    press_btn(2'b01);
    fb_edges(FE);
    check("R4 edges before hsync ignored", en, 2'b00);
    hs_edge(); fb_edges(FE - 1);
    check("R4 count starts after hsync", en, 2'b00);
    fb_edges(1);
    check("R4 toggle after hsync count", en, 2'b01);

    // R7: second press while pending is ignored
    press_btn(2'b10);
    hs_edge(); fb_edges(2);
    press_btn(2'b10);
    fb_edges(FE - 2);
    check("R7 one toggle per press", en, 2'b11);
    hs_edge(); fb_edges(FE);
    check("R7 second press left no request", en, 2'b11);

    // R8: request pulse behaves as a press
    req = 2'b01; tick(1); req = '0; tick(2);
    hs_edge(); fb_edges(FE);
    check("R8 request toggles channel 0", en, 2'b10);
    check("R6 led after request", led, 2'b10);

    // R1: reset in the middle of a pending toggle
    press_btn(2'b11);
    hs_edge(); fb_edges(3);
    rst_n = 1'b0; tick(3);
    check("R1 reset mid count", en, 2'b00);
    rst_n = 1'b1; tick(3);
    hs_edge(); fb_edges(FE);
    check("R1 pending cleared by reset", en, 2'b00);
    check("R6 led after reset", led, 2'b00);

    finish_run();
  end
endmodule